// File: doc/BRIEF.md
# Shared Pin Function Selector with Boot Strap

This block decides, for a small group of shared device pins, which on-chip function drives each pin's output value and output enable. Incoming pad values go back only to the function that owns the pin. Three pins are shared by a PWM channel, a bit of a parallel video colour bus and a GPIO line. Two pins are shared by the second UART and the disk-interface DMA handshake. Two more are shared by the first UART and two GPIO lines. A wide bus group is shared by a host port, the disk interface and an external-memory interface.

Software controls the choice through two control registers on a plain register bus (address, write strobe, write data, combinational read data). The host-port enable bit is preset from a two-bit boot-select strap that is sampled while reset is held. Software may change that bit afterwards. Routing is combinational from the registered control bits. For each pin group the block drives a one-hot owner status, so a checker can see that no pin ever has two drivers.

Top module: `pinmux_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the host enable (register 0 bit 0) loads 1 when `boot_strap` is 2'b10 and 0 for any other value. The disk enable (register 0 bit 1) and all of register 1 load 0. With those values the PWM pins are GPIO, the UART pairs follow R6 and R9, and the bus follows R10.
- R2: After reset is released, changes on `boot_strap` do not change the host enable. Software can overwrite the host enable through register 0.
- R3: A write with `reg_we` high takes effect at the next rising edge. Register 0 (address 0) holds host enable in bit 0 and disk enable in bit 1. Register 1 (address 1) holds the PWM enables in bits 2:0, the colour enable in bit 3, the UART0 enable in bit 4 and the UART1 enable in bit 5. Undefined bits read 0. Addresses 2 and 3 read 0, and writes to them change nothing.
- R4: When PWM enable i is set, pad i drives `pwm_src[i]` with its enable at 1, whatever the colour enable is.
- R5: When PWM enable i is clear and the colour enable is set, pad i drives `colour_src[i]` with its enable at 1. When both are clear, pad i takes `gpio_pwm_out[i]` and `gpio_pwm_oe[i]`.
- R6: When the disk enable is clear, the UART1 pair belongs to UART1 whatever the UART1 enable is. Pad 0 drives `uart1_txd` with its enable at 1. Pad 1 is an input (out 0, enable 0) that feeds `uart1_rxd`.
- R7: When the disk enable is set and the UART1 enable is clear, pad 0 drives `dma_ack` and pad 1 feeds `dma_req`.
- R8: When the disk enable and the UART1 enable are both set, the pair belongs to UART1 as in R6, and `dma_blocked` is 1. Otherwise `dma_blocked` is 0.
- R9: When the UART0 enable is set, UART0 pad 0 drives `uart0_txd` with its enable at 1, and pad 1 is an input (out 0, enable 0) that feeds `uart0_rxd`. When the UART0 enable is clear, both pads carry `gpio_u0_out` and `gpio_u0_oe`.
- R10: The bus pads belong to the host port when the host enable is set. Otherwise they belong to the disk interface when the disk enable is set. Otherwise they belong to the memory interface. The owner's out and enable vectors reach the pads.
- R11: A function that does not own its pins sees inactive input. UART receive lines read 1. `dma_req`, the GPIO inputs and the bus inputs read 0. The owner sees the pad value.
- R12: The status outputs are one-hot for every group. PWM pin i field `pwm_sel_st[3i+2:3i]` is 001 for PWM, 010 for colour and 100 for GPIO. `u1_sel_st` is 01 for UART1 and 10 for DMA. `u0_sel_st` is 01 for UART0 and 10 for GPIO. `bus_sel_st` is 001 for memory, 010 for disk and 100 for host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_strap | input | 2 | Boot-select strap, sampled during reset |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pwm_src | input | 3 | PWM channel outputs |
| colour_src | input | 3 | Video colour data bits |
| gpio_pwm_out | input | 3 | GPIO output values for PWM pins |
| gpio_pwm_oe | input | 3 | GPIO output enables for PWM pins |
| gpio_pwm_in | output | 3 | GPIO input values from PWM pins |
| pad_pwm_in | input | 3 | Pad input values, PWM pins |
| pad_pwm_out | output | 3 | Pad output values, PWM pins |
| pad_pwm_oe | output | 3 | Pad output enables, PWM pins |
| uart1_txd | input | 1 | UART1 transmit data |
| dma_ack | input | 1 | Disk DMA acknowledge |
| uart1_rxd | output | 1 | UART1 receive data |
| dma_req | output | 1 | Disk DMA request |
| pad_u1_in | input | 2 | Pad inputs, UART1 pair |
| pad_u1_out | output | 2 | Pad outputs, UART1 pair |
| pad_u1_oe | output | 2 | Pad output enables, UART1 pair |
| dma_blocked | output | 1 | DMA handshake unavailable |
| uart0_txd | input | 1 | UART0 transmit data |
| uart0_rxd | output | 1 | UART0 receive data |
| gpio_u0_out | input | 2 | GPIO outputs for UART0 pair |
| gpio_u0_oe | input | 2 | GPIO enables for UART0 pair |
| gpio_u0_in | output | 2 | GPIO inputs from UART0 pair |
| pad_u0_in | input | 2 | Pad inputs, UART0 pair |
| pad_u0_out | output | 2 | Pad outputs, UART0 pair |
| pad_u0_oe | output | 2 | Pad output enables, UART0 pair |
| host_out | input | 8 | Host port bus outputs |
| host_oe | input | 8 | Host port bus enables |
| host_in | output | 8 | Bus inputs to host port |
| disk_out | input | 8 | Disk interface bus outputs |
| disk_oe | input | 8 | Disk interface bus enables |
| disk_in | output | 8 | Bus inputs to disk interface |
| emif_out | input | 8 | Memory interface bus outputs |
| emif_oe | input | 8 | Memory interface bus enables |
| emif_in | output | 8 | Bus inputs to memory interface |
| pad_bus_in | input | 8 | Pad inputs, bus group |
| pad_bus_out | output | 8 | Pad outputs, bus group |
| pad_bus_oe | output | 8 | Pad output enables, bus group |
| pwm_sel_st | output | 9 | One-hot owner per PWM pin |
| u1_sel_st | output | 2 | One-hot owner, UART1 pair |
| u0_sel_st | output | 2 | One-hot owner, UART0 pair |
| bus_sel_st | output | 3 | One-hot owner, bus group |

## Verification
Each register write becomes visible one rising edge after it is presented. Register 0 and register 1 and every routing output follow from that edge. The bench drives the write on a falling edge and reads it back on the next falling edge. The strap value becomes visible on the first falling edge after reset drops. Routing and read data are combinational from the registers and the peripheral and pad inputs. The bench therefore checks them a short delay after it changes those inputs, with no clock edge in between. Its model of the registers is updated only after the edge that commits the write.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int PWM_PINS    = 3;
    localparam int REG_ADDR_W  = 2;
    localparam int REG_DATA_W  = 32;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTL0 = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_CTL1 = 2'd1;
    localparam logic [1:0]            STRAP_HOST = 2'b10;

    // register 0: bit0 host enable, bit1 disk enable
    typedef struct packed {
        logic disk_en;
        logic host_en;
    } ctl0_t;

    // register 1: bits2:0 pwm enables, bit3 colour, bit4 uart0, bit5 uart1
    typedef struct packed {
        logic                uart1_en;
        logic                uart0_en;
        logic                colour_en;
        logic [PWM_PINS-1:0] pwm_en;
    } ctl1_t;

    localparam int CTL0_W = $bits(ctl0_t);
    localparam int CTL1_W = $bits(ctl1_t);

    typedef enum logic [2:0] {
        PWM_OWN_PWM    = 3'b001,
        PWM_OWN_COLOUR = 3'b010,
        PWM_OWN_GPIO   = 3'b100
    } pwm_own_e;

    typedef enum logic [1:0] {
        U1_OWN_UART = 2'b01,
        U1_OWN_DMA  = 2'b10
    } u1_own_e;

    typedef enum logic [1:0] {
        U0_OWN_UART = 2'b01,
        U0_OWN_GPIO = 2'b10
    } u0_own_e;

    typedef enum logic [2:0] {
        BUS_OWN_EMIF = 3'b001,
        BUS_OWN_DISK = 3'b010,
        BUS_OWN_HOST = 3'b100
    } bus_own_e;

    typedef struct packed {
        pwm_own_e [PWM_PINS-1:0] pwm;
        u1_own_e                 u1;
        u0_own_e                 u0;
        bus_own_e                bus;
        logic                    dma_blocked;
    } route_sel_t;

    function automatic pwm_own_e pwm_owner(input logic pwm_en, input logic colour_en);
        if (pwm_en)         return PWM_OWN_PWM;
        else if (colour_en) return PWM_OWN_COLOUR;
        else                return PWM_OWN_GPIO;
    endfunction

    function automatic u1_own_e u1_owner(input logic disk_en, input logic uart1_en);
        if (disk_en && !uart1_en) return U1_OWN_DMA;
        else                      return U1_OWN_UART;
    endfunction

    function automatic u0_own_e u0_owner(input logic uart0_en);
        return uart0_en ? U0_OWN_UART : U0_OWN_GPIO;
    endfunction

    function automatic bus_own_e bus_owner(input logic host_en, input logic disk_en);
        if (host_en)      return BUS_OWN_HOST;
        else if (disk_en) return BUS_OWN_DISK;
        else              return BUS_OWN_EMIF;
    endfunction

endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int ADDR_W = REG_ADDR_W,
    parameter int DATA_W = REG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        boot_strap,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output ctl0_t             ctl0,
    output ctl1_t             ctl1
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl0.host_en <= (boot_strap == STRAP_HOST);
            ctl0.disk_en <= 1'b0;
            ctl1         <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                ADDR_CTL0: ctl0 <= ctl0_t'(reg_wdata[CTL0_W-1:0]);
                ADDR_CTL1: ctl1 <= ctl1_t'(reg_wdata[CTL1_W-1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTL0: reg_rdata[CTL0_W-1:0] = ctl0;
            ADDR_CTL1: reg_rdata[CTL1_W-1:0] = ctl1;
            default:   reg_rdata = '0;
        endcase
    end

    // R1: host enable after reset release reflects the strap seen during reset
    assert_strap_load_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ctl0.host_en == ($past(boot_strap) == STRAP_HOST));

    // R3: a write to register 1 lands one edge later
    assert_ctl1_write_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_we) && $past(reg_addr) == ADDR_CTL1 && !$past(rst))
        |-> ctl1 == ctl1_t'($past(reg_wdata[CTL1_W-1:0])));

    // R2: without a write to register 0, host enable holds
    assert_host_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(reg_we) && $past(reg_addr) == ADDR_CTL0))
        |-> $stable(ctl0.host_en));

endmodule

// File: rtl/pinmux_decode.sv
module pinmux_decode
    import pinmux_pkg::*;
(
    input  ctl0_t      ctl0,
    input  ctl1_t      ctl1,
    output route_sel_t sel
);

    pwm_own_e pwm_arr [PWM_PINS];

    for (genvar g = 0; g < PWM_PINS; g++) begin : g_pwm_own
        assign pwm_arr[g] = pwm_owner(ctl1.pwm_en[g], ctl1.colour_en);
    end

    always_comb begin
        for (int i = 0; i < PWM_PINS; i++) begin
            sel.pwm[i] = pwm_arr[i];
        end
        sel.u1          = u1_owner(ctl0.disk_en, ctl1.uart1_en);
        sel.u0          = u0_owner(ctl1.uart0_en);
        sel.bus         = bus_owner(ctl0.host_en, ctl0.disk_en);
        sel.dma_blocked = ctl0.disk_en & ctl1.uart1_en;
    end

endmodule

// File: rtl/pinmux_route.sv
module pinmux_route
    import pinmux_pkg::*;
#(
    parameter int BUS_PINS = 8
) (
    input  route_sel_t          sel,
    input  logic [PWM_PINS-1:0] pwm_src,
    input  logic [PWM_PINS-1:0] colour_src,
    input  logic [PWM_PINS-1:0] gpio_pwm_out,
    input  logic [PWM_PINS-1:0] gpio_pwm_oe,
    output logic [PWM_PINS-1:0] gpio_pwm_in,
    input  logic [PWM_PINS-1:0] pad_pwm_in,
    output logic [PWM_PINS-1:0] pad_pwm_out,
    output logic [PWM_PINS-1:0] pad_pwm_oe,
    input  logic                uart1_txd,
    input  logic                dma_ack,
    output logic                uart1_rxd,
    output logic                dma_req,
    input  logic [1:0]          pad_u1_in,
    output logic [1:0]          pad_u1_out,
    output logic [1:0]          pad_u1_oe,
    input  logic                uart0_txd,
    output logic                uart0_rxd,
    input  logic [1:0]          gpio_u0_out,
    input  logic [1:0]          gpio_u0_oe,
    output logic [1:0]          gpio_u0_in,
    input  logic [1:0]          pad_u0_in,
    output logic [1:0]          pad_u0_out,
    output logic [1:0]          pad_u0_oe,
    input  logic [BUS_PINS-1:0] host_out,
    input  logic [BUS_PINS-1:0] host_oe,
    output logic [BUS_PINS-1:0] host_in,
    input  logic [BUS_PINS-1:0] disk_out,
    input  logic [BUS_PINS-1:0] disk_oe,
    output logic [BUS_PINS-1:0] disk_in,
    input  logic [BUS_PINS-1:0] emif_out,
    input  logic [BUS_PINS-1:0] emif_oe,
    output logic [BUS_PINS-1:0] emif_in,
    input  logic [BUS_PINS-1:0] pad_bus_in,
    output logic [BUS_PINS-1:0] pad_bus_out,
    output logic [BUS_PINS-1:0] pad_bus_oe
);

    // ---- PWM / colour / GPIO pins, one lane each ----
    for (genvar g = 0; g < PWM_PINS; g++) begin : g_pwm_lane
        always_comb begin
            gpio_pwm_in[g] = 1'b0;
            case (sel.pwm[g])
                PWM_OWN_PWM: begin
                    pad_pwm_out[g] = pwm_src[g];
                    pad_pwm_oe[g]  = 1'b1;
                end
                PWM_OWN_COLOUR: begin
                    pad_pwm_out[g] = colour_src[g];
                    pad_pwm_oe[g]  = 1'b1;
                end
                default: begin
                    pad_pwm_out[g] = gpio_pwm_out[g];
                    pad_pwm_oe[g]  = gpio_pwm_oe[g];
                    gpio_pwm_in[g] = pad_pwm_in[g];
                end
            endcase
        end
    end

    // ---- UART1 / DMA handshake pair ----
    always_comb begin
        pad_u1_oe     = 2'b01;
        pad_u1_out[1] = 1'b0;
        if (sel.u1 == U1_OWN_DMA) begin
            pad_u1_out[0] = dma_ack;
            dma_req       = pad_u1_in[1];
            uart1_rxd     = 1'b1;
        end else begin
            pad_u1_out[0] = uart1_txd;
            dma_req       = 1'b0;
            uart1_rxd     = pad_u1_in[1];
        end
    end

    // ---- UART0 / GPIO pair ----
    always_comb begin
        if (sel.u0 == U0_OWN_UART) begin
            pad_u0_out = {1'b0, uart0_txd};
            pad_u0_oe  = 2'b01;
            uart0_rxd  = pad_u0_in[1];
            gpio_u0_in = 2'b00;
        end else begin
            pad_u0_out = gpio_u0_out;
            pad_u0_oe  = gpio_u0_oe;
            uart0_rxd  = 1'b1;
            gpio_u0_in = pad_u0_in;
        end
    end

    // ---- shared bus group ----
    always_comb begin
        host_in = '0;
        disk_in = '0;
        emif_in = '0;
        case (sel.bus)
            BUS_OWN_HOST: begin
                pad_bus_out = host_out;
                pad_bus_oe  = host_oe;
                host_in     = pad_bus_in;
            end
            BUS_OWN_DISK: begin
                pad_bus_out = disk_out;
                pad_bus_oe  = disk_oe;
                disk_in     = pad_bus_in;
            end
            default: begin
                pad_bus_out = emif_out;
                pad_bus_oe  = emif_oe;
                emif_in     = pad_bus_in;
            end
        endcase
    end

endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
    import pinmux_pkg::*;
#(
    parameter int BUS_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            boot_strap,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_we,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    input  logic [PWM_PINS-1:0]   pwm_src,
    input  logic [PWM_PINS-1:0]   colour_src,
    input  logic [PWM_PINS-1:0]   gpio_pwm_out,
    input  logic [PWM_PINS-1:0]   gpio_pwm_oe,
    output logic [PWM_PINS-1:0]   gpio_pwm_in,
    input  logic [PWM_PINS-1:0]   pad_pwm_in,
    output logic [PWM_PINS-1:0]   pad_pwm_out,
    output logic [PWM_PINS-1:0]   pad_pwm_oe,
    input  logic                  uart1_txd,
    input  logic                  dma_ack,
    output logic                  uart1_rxd,
    output logic                  dma_req,
    input  logic [1:0]            pad_u1_in,
    output logic [1:0]            pad_u1_out,
    output logic [1:0]            pad_u1_oe,
    output logic                  dma_blocked,
    input  logic                  uart0_txd,
    output logic                  uart0_rxd,
    input  logic [1:0]            gpio_u0_out,
    input  logic [1:0]            gpio_u0_oe,
    output logic [1:0]            gpio_u0_in,
    input  logic [1:0]            pad_u0_in,
    output logic [1:0]            pad_u0_out,
    output logic [1:0]            pad_u0_oe,
    input  logic [BUS_PINS-1:0]   host_out,
    input  logic [BUS_PINS-1:0]   host_oe,
    output logic [BUS_PINS-1:0]   host_in,
    input  logic [BUS_PINS-1:0]   disk_out,
    input  logic [BUS_PINS-1:0]   disk_oe,
    output logic [BUS_PINS-1:0]   disk_in,
    input  logic [BUS_PINS-1:0]   emif_out,
    input  logic [BUS_PINS-1:0]   emif_oe,
    output logic [BUS_PINS-1:0]   emif_in,
    input  logic [BUS_PINS-1:0]   pad_bus_in,
    output logic [BUS_PINS-1:0]   pad_bus_out,
    output logic [BUS_PINS-1:0]   pad_bus_oe,
    output logic [3*PWM_PINS-1:0] pwm_sel_st,
    output logic [1:0]            u1_sel_st,
    output logic [1:0]            u0_sel_st,
    output logic [2:0]            bus_sel_st
);

    ctl0_t      ctl0;
    ctl1_t      ctl1;
    route_sel_t sel;

    pinmux_regs #(
        .ADDR_W (REG_ADDR_W),
        .DATA_W (REG_DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .boot_strap (boot_strap),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ctl0       (ctl0),
        .ctl1       (ctl1)
    );

    pinmux_decode u_decode (
        .ctl0 (ctl0),
        .ctl1 (ctl1),
        .sel  (sel)
    );

    pinmux_route #(
        .BUS_PINS (BUS_PINS)
    ) u_route (
        .sel          (sel),
        .pwm_src      (pwm_src),
        .colour_src   (colour_src),
        .gpio_pwm_out (gpio_pwm_out),
        .gpio_pwm_oe  (gpio_pwm_oe),
        .gpio_pwm_in  (gpio_pwm_in),
        .pad_pwm_in   (pad_pwm_in),
        .pad_pwm_out  (pad_pwm_out),
        .pad_pwm_oe   (pad_pwm_oe),
        .uart1_txd    (uart1_txd),
        .dma_ack      (dma_ack),
        .uart1_rxd    (uart1_rxd),
        .dma_req      (dma_req),
        .pad_u1_in    (pad_u1_in),
        .pad_u1_out   (pad_u1_out),
        .pad_u1_oe    (pad_u1_oe),
        .uart0_txd    (uart0_txd),
        .uart0_rxd    (uart0_rxd),
        .gpio_u0_out  (gpio_u0_out),
        .gpio_u0_oe   (gpio_u0_oe),
        .gpio_u0_in   (gpio_u0_in),
        .pad_u0_in    (pad_u0_in),
        .pad_u0_out   (pad_u0_out),
        .pad_u0_oe    (pad_u0_oe),
        .host_out     (host_out),
        .host_oe      (host_oe),
        .host_in      (host_in),
        .disk_out     (disk_out),
        .disk_oe      (disk_oe),
        .disk_in      (disk_in),
        .emif_out     (emif_out),
        .emif_oe      (emif_oe),
        .emif_in      (emif_in),
        .pad_bus_in   (pad_bus_in),
        .pad_bus_out  (pad_bus_out),
        .pad_bus_oe   (pad_bus_oe)
    );

    assign pwm_sel_st  = sel.pwm;
    assign u1_sel_st   = sel.u1;
    assign u0_sel_st   = sel.u0;
    assign bus_sel_st  = sel.bus;
    assign dma_blocked = sel.dma_blocked;

    // R4: an enabled PWM always reaches its pad
    for (genvar g = 0; g < PWM_PINS; g++) begin : g_pwm_chk
        assert_pwm_wins_R4: assert property (@(posedge clk) disable iff (rst)
            ctl1.pwm_en[g] |-> (pad_pwm_out[g] == pwm_src[g] && pad_pwm_oe[g]));
        // R12: exactly one owner per PWM pin
        assert_pwm_onehot_R12: assert property (@(posedge clk) disable iff (rst)
            $countones(pwm_sel_st[3*g +: 3]) == 1);
    end

    // R6: disk interface off means UART1 transmit on pad 0
    assert_u1_default_R6: assert property (@(posedge clk) disable iff (rst)
        !ctl0.disk_en |-> (pad_u1_out[0] == uart1_txd && uart1_rxd == pad_u1_in[1]));

    // R7: handshake routing when the disk takes the pair
    assert_dma_route_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl0.disk_en && !ctl1.uart1_en) |-> (pad_u1_out[0] == dma_ack && dma_req == pad_u1_in[1]));

    // R8: blocked handshake leaves UART1 in charge
    assert_dma_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        dma_blocked |-> (!dma_req && uart1_rxd == pad_u1_in[1] && ctl0.disk_en));

    // R10: host enable dominates the bus
    assert_host_bus_R10: assert property (@(posedge clk) disable iff (rst)
        ctl0.host_en |-> (pad_bus_out == host_out && pad_bus_oe == host_oe && disk_in == '0));

    // R11: idle UART0 receive line reads high
    assert_u0_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !ctl1.uart0_en |-> uart0_rxd);

    // R12: one owner for every paired group
    assert_group_onehot_R12: assert property (@(posedge clk) disable iff (rst)
        $countones(bus_sel_st) == 1 && $countones(u1_sel_st) == 1 && $countones(u0_sel_st) == 1);

endmodule

// File: tb/tb_pinmux_ctrl.sv
module tb_pinmux_ctrl;

    localparam int  CLK_PERIOD = 10;
    localparam int  BUS_W      = 8;
    localparam int  NPWM       = 3;
    localparam longint WATCHDOG_CYC = 200000;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       boot_strap;
    logic [1:0]       reg_addr;
    logic             reg_we;
    logic [31:0]      reg_wdata;
    logic [31:0]      reg_rdata;
    logic [NPWM-1:0]  pwm_src, colour_src, gpio_pwm_out, gpio_pwm_oe, gpio_pwm_in;
    logic [NPWM-1:0]  pad_pwm_in, pad_pwm_out, pad_pwm_oe;
    logic             uart1_txd, dma_ack, uart1_rxd, dma_req, dma_blocked;
    logic [1:0]       pad_u1_in, pad_u1_out, pad_u1_oe;
    logic             uart0_txd, uart0_rxd;
    logic [1:0]       gpio_u0_out, gpio_u0_oe, gpio_u0_in, pad_u0_in, pad_u0_out, pad_u0_oe;
    logic [BUS_W-1:0] host_out, host_oe, host_in, disk_out, disk_oe, disk_in;
    logic [BUS_W-1:0] emif_out, emif_oe, emif_in, pad_bus_in, pad_bus_out, pad_bus_oe;
    logic [3*NPWM-1:0] pwm_sel_st;
    logic [1:0]       u1_sel_st, u0_sel_st;
    logic [2:0]       bus_sel_st;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // bench model of the control bits
    logic            m_host, m_disk, m_col, m_u0, m_u1;
    logic [NPWM-1:0] m_pwm;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinmux_ctrl #(.BUS_PINS(BUS_W)) dut (
        .clk(clk), .rst(rst), .boot_strap(boot_strap),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_src(pwm_src), .colour_src(colour_src), .gpio_pwm_out(gpio_pwm_out),
        .gpio_pwm_oe(gpio_pwm_oe), .gpio_pwm_in(gpio_pwm_in), .pad_pwm_in(pad_pwm_in),
        .pad_pwm_out(pad_pwm_out), .pad_pwm_oe(pad_pwm_oe),
        .uart1_txd(uart1_txd), .dma_ack(dma_ack), .uart1_rxd(uart1_rxd), .dma_req(dma_req),
        .pad_u1_in(pad_u1_in), .pad_u1_out(pad_u1_out), .pad_u1_oe(pad_u1_oe),
        .dma_blocked(dma_blocked),
        .uart0_txd(uart0_txd), .uart0_rxd(uart0_rxd), .gpio_u0_out(gpio_u0_out),
        .gpio_u0_oe(gpio_u0_oe), .gpio_u0_in(gpio_u0_in), .pad_u0_in(pad_u0_in),
        .pad_u0_out(pad_u0_out), .pad_u0_oe(pad_u0_oe),
        .host_out(host_out), .host_oe(host_oe), .host_in(host_in),
        .disk_out(disk_out), .disk_oe(disk_oe), .disk_in(disk_in),
        .emif_out(emif_out), .emif_oe(emif_oe), .emif_in(emif_in),
        .pad_bus_in(pad_bus_in), .pad_bus_out(pad_bus_out), .pad_bus_oe(pad_bus_oe),
        .pwm_sel_st(pwm_sel_st), .u1_sel_st(u1_sel_st), .u0_sel_st(u0_sel_st),
        .bus_sel_st(bus_sel_st)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctl0();
        return {30'd0, m_disk, m_host};
    endfunction

    function automatic logic [31:0] exp_ctl1();
        return {26'd0, m_u1, m_u0, m_col, m_pwm};
    endfunction

    task automatic randomize_inputs();
        pwm_src      = NPWM'($urandom);
        colour_src   = NPWM'($urandom);
        gpio_pwm_out = NPWM'($urandom);
        gpio_pwm_oe  = NPWM'($urandom);
        pad_pwm_in   = NPWM'($urandom);
        uart1_txd    = 1'($urandom);
        dma_ack      = 1'($urandom);
        pad_u1_in    = 2'($urandom);
        uart0_txd    = 1'($urandom);
        gpio_u0_out  = 2'($urandom);
        gpio_u0_oe   = 2'($urandom);
        pad_u0_in    = 2'($urandom);
        host_out     = BUS_W'($urandom);
        host_oe      = BUS_W'($urandom);
        disk_out     = BUS_W'($urandom);
        disk_oe      = BUS_W'($urandom);
        emif_out     = BUS_W'($urandom);
        emif_oe      = BUS_W'($urandom);
        pad_bus_in   = BUS_W'($urandom);
    endtask

    // compare every routing output with the model
    task automatic verify_routes();
        logic [NPWM-1:0]   e_out, e_oe, e_gin;
        logic [3*NPWM-1:0] e_sel;
        logic              u1_uart;
        logic [BUS_W-1:0]  e_bo, e_boe, e_hi, e_di, e_ei;
        logic [2:0]        e_bsel;
        for (int i = 0; i < NPWM; i++) begin
            if (m_pwm[i]) begin
                e_out[i] = pwm_src[i]; e_oe[i] = 1'b1; e_gin[i] = 1'b0; e_sel[3*i +: 3] = 3'b001;
            end else if (m_col) begin
                e_out[i] = colour_src[i]; e_oe[i] = 1'b1; e_gin[i] = 1'b0; e_sel[3*i +: 3] = 3'b010;
            end else begin
                e_out[i] = gpio_pwm_out[i]; e_oe[i] = gpio_pwm_oe[i]; e_gin[i] = pad_pwm_in[i];
                e_sel[3*i +: 3] = 3'b100;
            end
        end
        chk("R4/R5", "pad_pwm_out", 64'(pad_pwm_out), 64'(e_out));
        chk("R4/R5", "pad_pwm_oe", 64'(pad_pwm_oe), 64'(e_oe));
        chk("R11", "gpio_pwm_in", 64'(gpio_pwm_in), 64'(e_gin));
        chk("R12", "pwm_sel_st", 64'(pwm_sel_st), 64'(e_sel));

        u1_uart = !m_disk || m_u1;
        chk("R6/R7", "pad_u1_out", 64'(pad_u1_out), 64'({1'b0, u1_uart ? uart1_txd : dma_ack}));
        chk("R6/R7", "pad_u1_oe", 64'(pad_u1_oe), 64'(2'b01));
        chk("R11", "uart1_rxd", 64'(uart1_rxd), 64'(u1_uart ? pad_u1_in[1] : 1'b1));
        chk("R11", "dma_req", 64'(dma_req), 64'(u1_uart ? 1'b0 : pad_u1_in[1]));
        chk("R8", "dma_blocked", 64'(dma_blocked), 64'(m_disk & m_u1));
        chk("R12", "u1_sel_st", 64'(u1_sel_st), 64'(u1_uart ? 2'b01 : 2'b10));

        chk("R9", "pad_u0_out", 64'(pad_u0_out), 64'(m_u0 ? {1'b0, uart0_txd} : gpio_u0_out));
        chk("R9", "pad_u0_oe", 64'(pad_u0_oe), 64'(m_u0 ? 2'b01 : gpio_u0_oe));
        chk("R11", "uart0_rxd", 64'(uart0_rxd), 64'(m_u0 ? pad_u0_in[1] : 1'b1));
        chk("R11", "gpio_u0_in", 64'(gpio_u0_in), 64'(m_u0 ? 2'b00 : pad_u0_in));
        chk("R12", "u0_sel_st", 64'(u0_sel_st), 64'(m_u0 ? 2'b01 : 2'b10));

        e_hi = '0; e_di = '0; e_ei = '0;
        if (m_host) begin
            e_bo = host_out; e_boe = host_oe; e_hi = pad_bus_in; e_bsel = 3'b100;
        end else if (m_disk) begin
            e_bo = disk_out; e_boe = disk_oe; e_di = pad_bus_in; e_bsel = 3'b010;
        end else begin
            e_bo = emif_out; e_boe = emif_oe; e_ei = pad_bus_in; e_bsel = 3'b001;
        end
        chk("R10", "pad_bus_out", 64'(pad_bus_out), 64'(e_bo));
        chk("R10", "pad_bus_oe", 64'(pad_bus_oe), 64'(e_boe));
        chk("R11", "host_in", 64'(host_in), 64'(e_hi));
        chk("R11", "disk_in", 64'(disk_in), 64'(e_di));
        chk("R11", "emif_in", 64'(emif_in), 64'(e_ei));
        chk("R12", "bus_sel_st", 64'(bus_sel_st), 64'(e_bsel));
    endtask

    task automatic check_regs(input string req);
        @(negedge clk);
        reg_addr = 2'd0; #1;
        chk(req, "ctl0 read", 64'(reg_rdata), 64'(exp_ctl0()));
        reg_addr = 2'd1; #1;
        chk(req, "ctl1 read", 64'(reg_rdata), 64'(exp_ctl1()));
    endtask

    task automatic do_reset(input logic [1:0] strap);
        @(negedge clk);
        rst = 1'b1;
        boot_strap = strap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        boot_strap = ~strap;
        m_host = (strap == 2'b10);
        m_disk = 1'b0; m_pwm = '0; m_col = 1'b0; m_u0 = 1'b0; m_u1 = 1'b0;
        check_regs("R1");
        #1 verify_routes();
    endtask

    task automatic reg_write(input logic [1:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_addr  = addr;
        reg_wdata = data;
        reg_we    = 1'b1;
        @(posedge clk);
        #1;
        if (addr == 2'd0) begin
            m_host = data[0]; m_disk = data[1];
        end else if (addr == 2'd1) begin
            m_pwm = data[2:0]; m_col = data[3]; m_u0 = data[4]; m_u1 = data[5];
        end
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // watchdog
    initial begin
        for (longint c = 0; c < WATCHDOG_CYC; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; boot_strap = 2'b00; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        m_host = 0; m_disk = 0; m_pwm = '0; m_col = 0; m_u0 = 0; m_u1 = 0;
        randomize_inputs();

        // R1 / R2: every strap value
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
        end

        // R2: strap toggles after reset are ignored; software clears host enable
        do_reset(2'b10);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) boot_strap = 2'(k);
        end
        check_regs("R2");
        reg_write(2'd0, 32'h0);
        check_regs("R2");
        reg_write(2'd0, 32'h1);
        check_regs("R2");

        // R3: undefined bits read zero; unused addresses ignored
        reg_write(2'd1, 32'hFFFF_FFFF);
        check_regs("R3");
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_write(2'd3, 32'hFFFF_FFFF);
        check_regs("R3");
        @(negedge clk) reg_addr = 2'd2; #1;
        chk("R3", "addr2 read", 64'(reg_rdata), 64'd0);
        reg_addr = 2'd3; #1;
        chk("R3", "addr3 read", 64'(reg_rdata), 64'd0);

        // R4: pwm enabled with colour set
        reg_write(2'd1, 32'h0F);
        randomize_inputs(); #1 verify_routes();
        // R5: colour only, then GPIO only
        reg_write(2'd1, 32'h08);
        randomize_inputs(); #1 verify_routes();
        reg_write(2'd1, 32'h00);
        randomize_inputs(); #1 verify_routes();

        // R6/R7/R8: all disk / uart1 combinations with host off
        for (int c = 0; c < 4; c++) begin
            reg_write(2'd0, {30'd0, c[0], 1'b0});
            reg_write(2'd1, {26'd0, c[1], 5'd0});
            for (int r = 0; r < 3; r++) begin
                randomize_inputs(); #1 verify_routes();
            end
        end

        // R9: uart0 on and off
        reg_write(2'd1, 32'h10);
        randomize_inputs(); #1 verify_routes();
        reg_write(2'd1, 32'h00);
        randomize_inputs(); #1 verify_routes();

        // R10: bus priority over all host/disk combinations
        for (int c = 0; c < 4; c++) begin
            reg_write(2'd0, 32'(c));
            randomize_inputs(); #1 verify_routes();
        end

        // random mix of writes and input changes
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 4) == 0) begin
                reg_write(2'($urandom), $urandom);
                check_regs("R3");
            end
            @(negedge clk);
            randomize_inputs();
            #1 verify_routes();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule